// File: doc/BRIEF.md
# Device Interrupt Request Controller

This block gathers interrupt requests from a population of up to 256 I/O devices. Each device owns one request bit and one enable bit. Both are kept as eight 32-bit words, with device d sitting in word d/32 at bit d mod 32. Devices raise or drop their request with per-device set and clear strobes. The processor shapes the enable bits through a command-write port that carries a device number and the two-bit interrupt-control field of that device's command byte.

A request is always latched, whatever its enable bit says. The enable only hides it from the output. The block drives a pending flag when some device from 1 upward has both bits set and the processor's external-interrupt enable (bit 14 of its status word) is high. In the same cycle it presents the number of the lowest-numbered such device as the vector. An acknowledge pulse retires the request of the presented device. The winner search runs in two stages: it first picks the lowest nonzero 32-bit word, then the lowest set bit within that word.

Top module: `dev_irq_ctrl`

## Requirements
- R1: A set strobe for device d makes its request bit 1 from the next cycle on, whatever its enable bit, and the bit stays set until it is cleared.
- R2: A clear strobe for device d drops its request bit on the next cycle. If set and clear for the same device arrive in the same cycle, the request ends up set.
- R3: A command write with control field 1 (command byte bits 7:6 = 01) sets the addressed device's enable bit. Field 2 (10) clears it.
- R4: Control field 3 (11) inverts the addressed enable bit. Field 0 leaves it unchanged.
- R5: A request whose enable bit is 0 is not reported. Setting the enable later reveals the held request without any new strobe.
- R6: Device 0 never yields a pending interrupt, even with its request and enable bits both set.
- R7: The pending output is 0 while the external-interrupt enable input (status word bit 14) is 0. The vector is not affected by that input.
- R8: The vector equals the lowest-numbered device in 1..255 whose request and enable bits are both 1, combinationally in the same cycle. It is 0 when no such device exists.
- R9: With pending high, an acknowledge clears the request of the device on the vector by the next cycle, unless a set strobe for that device arrives in the same cycle. An acknowledge while pending is low changes nothing.
- R10: Reset clears every request and enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_stb | input | 256 | Per-device request set strobes, bit d for device d |
| clr_stb | input | 256 | Per-device request clear strobes |
| cmd_we | input | 1 | Command write strobe |
| cmd_dev | input | 8 | Device number addressed by the command |
| cmd_ictl | input | 2 | Interrupt-control field, bits 7:6 of the command byte |
| psw_exi | input | 1 | External-interrupt enable, status word bit 14 |
| ack | input | 1 | Acknowledge of the presented interrupt |
| irq_pend | output | 1 | An enabled request is pending and allowed |
| irq_vec | output | 8 | Number of the winning device |

## Verification
The assertions assume that every input carries a known 0 or 1 value on each rising edge. They also assume that the device number on the command port is never X. Every bit pattern is legal, including set, clear and acknowledge hitting the same device at once. The stimulus therefore drives all inputs from fully defined values on the falling edge. It mixes directed collisions with sparse random strobe vectors.

// File: rtl/dev_irq_ctrl.sv
module dev_irq_ctrl #(
  parameter int NDEV  = 256,
  parameter int WORDW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NDEV-1:0]          set_stb,
  input  logic [NDEV-1:0]          clr_stb,
  input  logic                     cmd_we,
  input  logic [$clog2(NDEV)-1:0]  cmd_dev,
  input  logic [1:0]               cmd_ictl,
  input  logic                     psw_exi,
  input  logic                     ack,
  output logic                     irq_pend,
  output logic [$clog2(NDEV)-1:0]  irq_vec
);
  localparam int NWORD = NDEV / WORDW;
  localparam int IDW   = $clog2(NDEV);
  localparam int BW    = $clog2(WORDW);
  localparam int WW    = $clog2(NWORD);

  logic [NDEV-1:0]  req_q, enb_q, enb_d, live, ack_mask;
  logic [NWORD-1:0] wnz;
  logic [WW-1:0]    wsel;
  logic [BW-1:0]    bsel;
  logic [WORDW-1:0] wsl;

  assign live     = req_q & enb_q & ~NDEV'(1);
  assign ack_mask = (ack && irq_pend) ? (NDEV'(1) << irq_vec) : '0;

  always_comb begin
    enb_d = enb_q;
    if (cmd_we) begin
      case (cmd_ictl)
        2'd1:    enb_d[cmd_dev] = 1'b1;
        2'd2:    enb_d[cmd_dev] = 1'b0;
        2'd3:    enb_d[cmd_dev] = ~enb_q[cmd_dev];
        default: enb_d[cmd_dev] = enb_q[cmd_dev];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      enb_q <= '0;
    end else begin
      req_q <= (req_q & ~clr_stb & ~ack_mask) | set_stb;
      enb_q <= enb_d;
    end
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign wnz[w] = |live[w*WORDW +: WORDW];
  end

  always_comb begin
    wsel = '0;
    for (int w = NWORD - 1; w >= 0; w--)
      if (wnz[w]) wsel = WW'(w);
  end

  assign wsl = live[wsel*WORDW +: WORDW];

  always_comb begin
    bsel = '0;
    for (int b = WORDW - 1; b >= 0; b--)
      if (wsl[b]) bsel = BW'(b);
  end

  assign irq_vec  = IDW'({wsel, bsel});
  assign irq_pend = psw_exi && (|wnz);

  // R6 R8
  vec_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (irq_vec != '0) && req_q[irq_vec] && enb_q[irq_vec]);

  // R8
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> ((live & ((NDEV'(1) << irq_vec) - NDEV'(1))) == '0));

  // R1
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_stb) |=> ((req_q & $past(set_stb)) == $past(set_stb)));

  // R9
  ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_pend && !set_stb[irq_vec]) |=> !req_q[$past(irq_vec)]);

  // R3
  enb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_ictl == 2'd1) |=> enb_q[$past(cmd_dev)]);

  // R3
  enb_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_ictl == 2'd2) |=> !enb_q[$past(cmd_dev)]);

  // R4
  enb_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_ictl == 2'd3) |=> (enb_q[$past(cmd_dev)] != $past(enb_q[cmd_dev])));

  // R7
  exi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psw_exi |-> !irq_pend);
endmodule

// File: tb/dev_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dev_irq_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] set_stb = '0, clr_stb = '0;
  logic         cmd_we = 1'b0;
  logic [7:0]   cmd_dev = '0;
  logic [1:0]   cmd_ictl = '0;
  logic         psw_exi = 1'b0, ack = 1'b0;
  logic         irq_pend;
  logic [7:0]   irq_vec;

  bit [255:0] mreq, menb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dev_irq_ctrl u_dut (.clk, .rst_n, .set_stb, .clr_stb, .cmd_we, .cmd_dev,
                      .cmd_ictl, .psw_exi, .ack, .irq_pend, .irq_vec);

  function automatic int winner();
    for (int d = 1; d < 256; d++) if (mreq[d] && menb[d]) return d;
    return 0;
  endfunction

  task automatic compare(input string r);
    bit ep; int ev;
    ev = winner();
    ep = psw_exi && (ev != 0);
    checks++;
    if (irq_pend !== ep || irq_vec !== ev[7:0]) begin
      fails++;
      $display("FAIL %s: pend=%0b vec=%0d expected pend=%0b vec=%0d", r, irq_pend, irq_vec, ep, ev);
    end
  endtask

  task automatic step(input bit [255:0] s, input bit [255:0] c, input bit we, input int dev,
                      input bit [1:0] ic, input bit ex, input bit a, input string r);
    bit ep; int ev;
    set_stb = s; clr_stb = c; cmd_we = we; cmd_dev = dev[7:0]; cmd_ictl = ic;
    psw_exi = ex; ack = a;
    #1;
    compare(r);
    ev = winner();
    ep = ex && (ev != 0);
    for (int d = 0; d < 256; d++) begin
      if (c[d]) mreq[d] = 1'b0;
      if (a && ep && d == ev) mreq[d] = 1'b0;
      if (s[d]) mreq[d] = 1'b1;
    end
    if (we) case (ic)
      2'd1: menb[dev] = 1'b1;
      2'd2: menb[dev] = 1'b0;
      2'd3: menb[dev] = ~menb[dev];
      default: ;
    endcase
    @(posedge clk); @(negedge clk);
  endtask

  function automatic bit [255:0] one(input int d);
    return 256'(1) << d;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    set_stb = '0; clr_stb = '0; cmd_we = 0; ack = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    mreq = '0; menb = '0;
    rst_n = 1'b1;
  endtask

  task automatic idle(input bit ex, input string r);
    step('0, '0, 0, 0, 0, ex, 0, r);
  endtask

  task automatic cmd(input int d, input bit [1:0] ic, input string r);
    step('0, '0, 1, d, ic, 1, 0, r);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    idle(1, "R10");
    step(one(5), '0, 0, 0, 0, 1, 0, "R1");
    idle(1, "R5");
    cmd(5, 2'd1, "R3");
    idle(1, "R5");
    cmd(5, 2'd2, "R3");
    idle(1, "R3");
    cmd(5, 2'd0, "R4");
    idle(1, "R4");
    cmd(5, 2'd3, "R4");
    idle(1, "R4");
    cmd(5, 2'd3, "R4");
    idle(1, "R4");
    step(one(0), '0, 1, 0, 2'd1, 1, 0, "R6");
    idle(1, "R6");
    step(one(40) | one(200) | one(33), '0, 1, 40, 2'd1, 1, 0, "R8");
    cmd(200, 2'd1, "R8");
    cmd(33, 2'd1, "R8");
    idle(1, "R8");
    step('0, '0, 0, 0, 0, 1, 1, "R9");
    idle(1, "R9");
    step(one(40), '0, 0, 0, 0, 1, 1, "R9");
    idle(1, "R9");
    idle(0, "R7");
    step('0, '0, 0, 0, 0, 0, 1, "R9");
    idle(1, "R9");
    step(one(40), one(40), 0, 0, 0, 1, 0, "R2");
    idle(1, "R2");
    step('0, one(40), 0, 0, 0, 1, 0, "R2");
    idle(1, "R2");
    for (int i = 0; i < 4000; i++) begin
      bit [255:0] s, c;
      s = '0; c = '0;
      for (int k = 0; k < 3; k++) begin
        if ($urandom_range(0, 3) == 0) s[$urandom_range(0, 255)] = 1'b1;
        if ($urandom_range(0, 3) == 0) c[$urandom_range(0, 255)] = 1'b1;
      end
      if (i % 97 == 0) s[$urandom_range(0, 7)] = 1'b1;
      step(s, c, $urandom_range(0, 1), $urandom_range(0, 255), 2'($urandom_range(0, 3)),
           $urandom_range(0, 7) != 0, $urandom_range(0, 2) == 0, "R8");
    end
    step(one(9), '0, 1, 9, 2'd1, 1, 0, "R1");
    do_reset();
    idle(1, "R10");
    cmd(9, 2'd1, "R10");
    idle(1, "R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule